// File: doc/BRIEF.md
# Posted Write Buffer Bridge

This block takes write requests from a 64-bit internal system bus and issues them as transactions on a 32-bit PCI-style initiator port. The address space of each write selects how it is handled. A memory-space write is posted: the block acknowledges it in the same cycle, stores it in a 32-byte buffer and forwards it later. A write to I/O, configuration or special-cycle space is connected: the requester keeps its request raised, and the acknowledge comes only after the bridge has won the PCI bus and delivered both halves of the data.

The buffer has four 64-bit slots. It holds either up to four single-beat writes or one four-beat burst. Each slot keeps an address, 64 bits of data and an 8-bit byte-enable mask. A single write drains as one PCI transaction with two data phases. A burst drains as one transaction with eight data phases, and that transaction does not start until all four beats are in the buffer. If the target disconnects, the bridge requests the bus again and restarts at the first word that was not delivered. Writes reach the PCI port in the order they were accepted.

Top module: `write_post_bridge`

## Requirements
- R1: A single-beat write with sb_space = 0 (memory) and sb_burst = 0 has sb_ack high in the same cycle it is presented when these conditions hold: fewer than four slots are occupied, the buffer does not hold a burst, and no connected write is outstanding.
- R2: Once four slots are occupied, a further memory write sees sb_ack low. It is accepted in a later cycle after a slot has drained. buf_empty is 1 exactly when no slot is occupied.
- R3: The first beat of a burst (sb_burst = 1) is acknowledged only when the buffer is empty. The three beats after it are each acknowledged in the cycle they are presented.
- R4: The data phases of a slot on the PCI port follow this layout. The first phase carries sb_wdata[31:0] with pci_be = sb_be[3:0] at the slot's address. The second phase carries sb_wdata[63:32] with pci_be = sb_be[7:4] at the address plus 4. A single write forms one transaction with one address phase.
- R5: A burst is sent as one transaction of eight data phases at ascending addresses 4 bytes apart, starting at the first beat's address. No PCI request is raised while any of its beats has not yet been posted.
- R6: pci_cmd in the address phase is set by sb_space: 0 (memory) gives 0111, 1 (I/O) gives 0011, 2 (configuration) gives 1011 and 3 (special cycle) gives 0001. A burst always uses 0111.
- R7: A connected write (sb_space != 0) waits until every posted write ahead of it has completed on PCI. Its sb_ack is raised in the cycle right after its final data phase is accepted, and the buffer is empty at that point.
- R8: Data words appear on the PCI port in the order in which their writes were accepted.
- R9: pci_req is raised while data waits and no transaction is active. An address phase (pci_addr_vld) follows only a cycle in which pci_req and pci_gnt were both high. At most one of pci_req, pci_addr_vld and pci_dat_vld is high in any cycle.
- R10: pci_stop ends the transaction. A word that has pci_trdy high in the same cycle counts as delivered. The bridge then re-arbitrates and resumes at the first undelivered word, so no word is lost or sent twice.
- R11: While pci_dat_vld is high and neither pci_trdy nor pci_stop is high, pci_wdata, pci_be and pci_addr hold their values into the next cycle.
- R12: After reset, the buffer is empty and pci_req, pci_addr_vld, pci_dat_vld and sb_ack are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_req | input | 1 | System-bus write request |
| sb_burst | input | 1 | Request is one beat of a four-beat burst |
| sb_space | input | 2 | Target space: 0 memory, 1 I/O, 2 configuration, 3 special |
| sb_addr | input | 32 | Byte address of the beat, 8-byte aligned |
| sb_wdata | input | 64 | Write data |
| sb_be | input | 8 | Byte enables; bit n covers sb_wdata[8n+7:8n] |
| sb_ack | output | 1 | Write accepted in this cycle |
| buf_empty | output | 1 | No slot occupied |
| pci_req | output | 1 | Bus request |
| pci_gnt | input | 1 | Bus grant |
| pci_addr_vld | output | 1 | Address phase |
| pci_addr | output | 32 | Address of the current word |
| pci_cmd | output | 4 | Bus command |
| pci_dat_vld | output | 1 | Data phase |
| pci_wdata | output | 32 | Data word |
| pci_be | output | 4 | Byte enables of the data word |
| pci_last | output | 1 | Current data phase is the final one of the transaction |
| pci_trdy | input | 1 | Target accepts the current word |
| pci_stop | input | 1 | Target disconnects after this cycle |

## Verification
The hardest case to reach from the ports is a disconnect at each possible point of a burst. The stimulus covers every word position, both with the word taken and without it, and adds target wait states so that held data and a resume address after a stall also occur. A connected write queued behind a posted one needs the grant to be withheld while both wait. The bench keeps the grant low for a fixed number of cycles, then measures the acknowledge cycle against the cycle the last word was delivered.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
    localparam int ADDR_W   = 32;
    localparam int SB_W     = 64;
    localparam int PCI_W    = 32;
    localparam int SB_BE_W  = SB_W / 8;
    localparam int PCI_BE_W = PCI_W / 8;

    typedef enum logic [1:0] {
        SP_MEM = 2'd0,
        SP_IO  = 2'd1,
        SP_CFG = 2'd2,
        SP_SPC = 2'd3
    } space_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [SB_W-1:0]    data;
        logic [SB_BE_W-1:0] be;
        space_e             space;
    } entry_t;

    function automatic logic [3:0] write_cmd(space_e sp);
        case (sp)
            SP_IO:   return 4'b0011;
            SP_CFG:  return 4'b1011;
            SP_SPC:  return 4'b0001;
            default: return 4'b0111;
        endcase
    endfunction
endpackage

// File: rtl/wpb_buf.sv
module wpb_buf
    import wpb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  entry_t           push_ent,
    input  logic             pop,
    output entry_t           head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        entry_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]   wr;
        logic [PTR_W-1:0]   rd;
        logic [CNT_W-1:0]   cnt;
    } buf_state_t;

    buf_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.slot[s_q.wr] = push_ent;
            s_d.wr           = s_q.wr + 1'b1;
        end
        if (pop) begin
            s_d.rd = s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.slot[s_q.rd];
    assign count = s_q.cnt;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt < CNT_W'(DEPTH)));
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));
endmodule

// File: rtl/wpb_admit.sv
module wpb_admit
    import wpb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int BEATS = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int BT_W  = $clog2(BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sb_req,
    input  logic             sb_burst,
    input  space_e           sb_space,
    input  logic [CNT_W-1:0] count,
    input  logic             pop,
    output logic             sb_ack,
    output logic             push,
    output logic             burst_mode,
    output logic             burst_open
);
    typedef enum logic [1:0] {CN_IDLE, CN_WAIT, CN_DONE} conn_e;

    typedef struct packed {
        logic            burst_mode;
        logic [BT_W-1:0] beats;
        conn_e           conn;
    } adm_state_t;

    adm_state_t s_d, s_q;

    logic room, empty, free;
    logic acc_single, acc_bfirst, acc_bnext, cap_conn;

    always_comb begin
        room  = count < CNT_W'(DEPTH);
        empty = count == '0;
        free  = !s_q.burst_mode && (s_q.conn == CN_IDLE);

        acc_single = sb_req && !sb_burst && (sb_space == SP_MEM) && room && free;
        acc_bfirst = sb_req && sb_burst && empty && free;
        acc_bnext  = sb_req && sb_burst && s_q.burst_mode && (s_q.beats < BT_W'(BEATS));
        cap_conn   = sb_req && !sb_burst && (sb_space != SP_MEM) && empty && free;

        push   = acc_single || acc_bfirst || acc_bnext || cap_conn;
        sb_ack = acc_single || acc_bfirst || acc_bnext || (sb_req && s_q.conn == CN_DONE);

        s_d = s_q;
        if (acc_bfirst) begin
            s_d.burst_mode = 1'b1;
            s_d.beats      = BT_W'(1);
        end else if (acc_bnext) begin
            s_d.beats = s_q.beats + 1'b1;
        end
        if (s_q.burst_mode && pop && count == CNT_W'(1)) begin
            s_d.burst_mode = 1'b0;
            s_d.beats      = '0;
        end
        case (s_q.conn)
            CN_IDLE: if (cap_conn) s_d.conn = CN_WAIT;
            CN_WAIT: if (pop)      s_d.conn = CN_DONE;
            CN_DONE: if (sb_req)   s_d.conn = CN_IDLE;
            default:               s_d.conn = CN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{burst_mode: 1'b0, beats: '0, conn: CN_IDLE};
        else        s_q <= s_d;
    end

    assign burst_mode = s_q.burst_mode;
    assign burst_open = s_q.burst_mode && (s_q.beats < BT_W'(BEATS));

    assert_burst_into_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_ack && sb_burst && !s_q.burst_mode) |-> (count == '0));
    assert_connected_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_ack && !sb_burst && sb_space != SP_MEM) |-> (count == '0));
    assert_posted_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_ack && !sb_burst && sb_space == SP_MEM) |=> (count != '0));
endmodule

// File: rtl/wpb_drain.sv
module wpb_drain
    import wpb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int WORDS = SB_W / PCI_W,
    localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  entry_t              head,
    input  logic [CNT_W-1:0]    count,
    input  logic                burst_mode,
    input  logic                burst_open,
    input  logic                pci_gnt,
    input  logic                pci_trdy,
    input  logic                pci_stop,
    output logic                pop,
    output logic                pci_req,
    output logic                pci_addr_vld,
    output logic                pci_dat_vld,
    output logic                pci_last,
    output logic [ADDR_W-1:0]   pci_addr,
    output logic [3:0]          pci_cmd,
    output logic [PCI_W-1:0]    pci_wdata,
    output logic [PCI_BE_W-1:0] pci_be
);
    typedef enum logic [1:0] {DR_IDLE, DR_REQ, DR_ADDR, DR_DATA} dr_e;

    typedef struct packed {
        dr_e             st;
        logic [WI_W-1:0] widx;
    } dr_state_t;

    dr_state_t s_d, s_q;
    logic work, last_word;

    always_comb begin
        work      = (count != '0) && !burst_open;
        last_word = s_q.widx == WI_W'(WORDS - 1);

        pci_req      = s_q.st == DR_REQ;
        pci_addr_vld = s_q.st == DR_ADDR;
        pci_dat_vld  = s_q.st == DR_DATA;
        pci_last     = pci_dat_vld && last_word && (!burst_mode || count == CNT_W'(1));
        pci_addr     = head.addr + ADDR_W'(32'(s_q.widx) * PCI_BE_W);
        pci_cmd      = write_cmd(head.space);
        pci_wdata    = head.data[s_q.widx * PCI_W +: PCI_W];
        pci_be       = head.be[s_q.widx * PCI_BE_W +: PCI_BE_W];

        pop = 1'b0;
        s_d = s_q;
        case (s_q.st)
            DR_IDLE: if (work)    s_d.st = DR_REQ;
            DR_REQ:  if (pci_gnt) s_d.st = DR_ADDR;
            DR_ADDR:              s_d.st = DR_DATA;
            DR_DATA: begin
                if (pci_trdy) begin
                    if (last_word) begin
                        pop      = 1'b1;
                        s_d.widx = '0;
                    end else begin
                        s_d.widx = s_q.widx + 1'b1;
                    end
                end
                if ((pci_trdy && pci_last) || pci_stop) s_d.st = DR_IDLE;
            end
            default: s_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: DR_IDLE, widx: '0};
        else        s_q <= s_d;
    end

    assert_addr_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pci_addr_vld |-> $past(pci_req && pci_gnt));
    assert_single_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pci_req, pci_addr_vld, pci_dat_vld}));
    assert_hold_on_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_dat_vld && !pci_trdy && !pci_stop) |=>
            (pci_dat_vld && $stable(pci_wdata) && $stable(pci_be) && $stable(pci_addr)));
    assert_no_req_while_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_open |-> !pci_addr_vld && !pci_dat_vld);
endmodule

// File: rtl/write_post_bridge.sv
module write_post_bridge
    import wpb_pkg::*;
#(
    parameter int BUF_BYTES   = 32,
    parameter int BURST_BEATS = 4,
    localparam int DEPTH = BUF_BYTES / SB_BE_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sb_req,
    input  logic        sb_burst,
    input  logic [1:0]  sb_space,
    input  logic [31:0] sb_addr,
    input  logic [63:0] sb_wdata,
    input  logic [7:0]  sb_be,
    output logic        sb_ack,
    output logic        buf_empty,
    output logic        pci_req,
    input  logic        pci_gnt,
    output logic        pci_addr_vld,
    output logic [31:0] pci_addr,
    output logic [3:0]  pci_cmd,
    output logic        pci_dat_vld,
    output logic [31:0] pci_wdata,
    output logic [3:0]  pci_be,
    output logic        pci_last,
    input  logic        pci_trdy,
    input  logic        pci_stop
);
    entry_t           push_ent, head;
    logic             push, pop, burst_mode, burst_open;
    logic [CNT_W-1:0] count;
    space_e           space_in;

    assign space_in = space_e'(sb_space);

    always_comb begin
        push_ent.addr  = sb_addr;
        push_ent.data  = sb_wdata;
        push_ent.be    = sb_be;
        push_ent.space = sb_burst ? SP_MEM : space_in;
    end

    wpb_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent),
        .pop(pop), .head(head), .count(count)
    );

    wpb_admit #(.DEPTH(DEPTH), .BEATS(BURST_BEATS)) u_admit (
        .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_burst(sb_burst),
        .sb_space(space_in), .count(count), .pop(pop), .sb_ack(sb_ack),
        .push(push), .burst_mode(burst_mode), .burst_open(burst_open)
    );

    wpb_drain #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n), .head(head), .count(count),
        .burst_mode(burst_mode), .burst_open(burst_open),
        .pci_gnt(pci_gnt), .pci_trdy(pci_trdy), .pci_stop(pci_stop),
        .pop(pop), .pci_req(pci_req), .pci_addr_vld(pci_addr_vld),
        .pci_dat_vld(pci_dat_vld), .pci_last(pci_last), .pci_addr(pci_addr),
        .pci_cmd(pci_cmd), .pci_wdata(pci_wdata), .pci_be(pci_be)
    );

    assign buf_empty = count == '0;

    assert_empty_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && !sb_ack) |=> !pci_dat_vld || !$past(pci_dat_vld && pci_trdy));
endmodule

// File: tb/test_write_post_bridge.sv
module test_write_post_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        sb_req = 0, sb_burst = 0;
    logic [1:0]  sb_space = 0;
    logic [31:0] sb_addr = 0;
    logic [63:0] sb_wdata = 0;
    logic [7:0]  sb_be = 0;
    logic        sb_ack, buf_empty;
    logic        pci_req, pci_addr_vld, pci_dat_vld, pci_last;
    logic        pci_gnt = 0, pci_trdy = 0, pci_stop = 0;
    logic [31:0] pci_addr, pci_wdata;
    logic [3:0]  pci_cmd, pci_be;

    write_post_bridge i_write_post_bridge (
        .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_burst(sb_burst),
        .sb_space(sb_space), .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_be(sb_be),
        .sb_ack(sb_ack), .buf_empty(buf_empty), .pci_req(pci_req), .pci_gnt(pci_gnt),
        .pci_addr_vld(pci_addr_vld), .pci_addr(pci_addr), .pci_cmd(pci_cmd),
        .pci_dat_vld(pci_dat_vld), .pci_wdata(pci_wdata), .pci_be(pci_be),
        .pci_last(pci_last), .pci_trdy(pci_trdy), .pci_stop(pci_stop)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // target model state and delivered-word log
    logic [31:0] lg_addr [16];
    logic [31:0] lg_data [16];
    logic [3:0]  lg_be   [16];
    logic [3:0]  lg_cmd  [16];
    int nwords = 0, naddr = 0, last_cyc = 0, stop_at = -1, wait_n = 0, wait_ctr = 0;
    bit stop_with = 0, gnt_en = 0;
    logic [31:0] cur_addr = 0;
    logic [3:0]  cur_cmd = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pci_gnt = 0; pci_trdy = 0; pci_stop = 0;
            end else begin
                pci_gnt  = pci_req && gnt_en;
                pci_trdy = 0;
                pci_stop = 0;
                if (pci_addr_vld) begin
                    cur_addr = pci_addr;
                    cur_cmd  = pci_cmd;
                    naddr++;
                end
                if (pci_dat_vld) begin
                    if (wait_ctr < wait_n) wait_ctr++;
                    else begin wait_ctr = 0; pci_trdy = 1; end
                    if (stop_at == nwords) begin
                        if (stop_with && pci_trdy) begin pci_stop = 1; stop_at = -1; end
                        else if (!stop_with) begin pci_trdy = 0; pci_stop = 1; stop_at = -1; end
                    end
                    if (pci_trdy && nwords < 16) begin
                        lg_addr[nwords] = cur_addr;
                        lg_data[nwords] = pci_wdata;
                        lg_be[nwords]   = pci_be;
                        lg_cmd[nwords]  = cur_cmd;
                        cur_addr        = cur_addr + 4;
                        last_cyc        = cyc;
                        nwords++;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_entry(input string req, input int j, input logic [31:0] a,
                             input logic [63:0] d, input logic [7:0] be, input logic [3:0] cmd);
        chk(req, "low word address", lg_addr[j], a);
        chk(req, "low word data", lg_data[j], d[31:0]);
        chk(req, "low word enables", lg_be[j], be[3:0]);
        chk(req, "command", lg_cmd[j], cmd);
        chk(req, "high word address", lg_addr[j+1], a + 4);
        chk(req, "high word data", lg_data[j+1], d[63:32]);
        chk(req, "high word enables", lg_be[j+1], be[7:4]);
    endtask

    function automatic logic [63:0] mkd(int t, int i);
        return {32'h8000_0000 + 32'(t * 64 + i * 2 + 1), 32'h4000_0000 + 32'(t * 64 + i * 2)};
    endfunction
    function automatic logic [7:0] mkbe(int t, int i);
        return 8'((t * 29 + i * 53 + 7) & 255);
    endfunction
    function automatic logic [31:0] mka(int t, int i, int stride);
        return 32'h1000_0000 + 32'(t * 256 + i * stride);
    endfunction

    task automatic sb_put(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                          input logic [1:0] sp, input bit bu, input int maxw,
                          output bit ok, output int waited, output int acc);
        ok = 0; waited = 0; acc = 0;
        sb_req = 1; sb_addr = a; sb_wdata = d; sb_be = be; sb_space = sp; sb_burst = bu;
        forever begin
            #1;
            if (sb_ack) begin ok = 1; acc = cyc; @(negedge clk); break; end
            if (waited >= maxw) begin @(negedge clk); break; end
            waited++;
            @(negedge clk);
        end
        sb_req = 0; sb_burst = 0;
    endtask

    task automatic wait_words(input int n);
        for (int k = 0; k < 3000 && nwords < n; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_log();
        nwords = 0; naddr = 0; stop_at = -1; wait_n = 0; wait_ctr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int waited, acc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "buf_empty", buf_empty, 1);
        chk("R12", "sb_ack", sb_ack, 0);
        chk("R12", "pci_req", pci_req, 0);
        chk("R12", "phases", {pci_addr_vld, pci_dat_vld}, 0);

        // R1 R2 R4 R8: singles posted while the grant is withheld
        for (int n = 1; n <= 4; n++) begin
            int tot;
            clear_log();
            gnt_en = 0;
            for (int i = 0; i < n; i++) begin
                sb_put(mka(n, i, 24), mkd(n, i), mkbe(n, i), 2'd0, 0, 0, ok, waited, acc);
                chk("R1", "immediate ack", ok, 1);
            end
            chk("R2", "buf_empty while holding", buf_empty, 0);
            tot = n;
            if (n == 4) begin
                sb_put(mka(n, 4, 24), mkd(n, 4), mkbe(n, 4), 2'd0, 0, 5, ok, waited, acc);
                chk("R2", "stall when full", ok, 0);
                gnt_en = 1;
                sb_put(mka(n, 4, 24), mkd(n, 4), mkbe(n, 4), 2'd0, 0, 500, ok, waited, acc);
                chk("R2", "accept after drain", ok, 1);
                tot = 5;
            end
            gnt_en = 1;
            wait_words(2 * tot);
            chk("R8", "word count", nwords, 2 * tot);
            for (int i = 0; i < tot; i++)
                chk_entry("R4", 2 * i, mka(n, i, 24), mkd(n, i), mkbe(n, i), 4'b0111);
            chk("R4", "one address phase per single", naddr, tot);
            chk("R2", "buf_empty after drain", buf_empty, 1);
        end

        // R3 R5 R10 R11: burst with disconnect at every word, with and without data
        for (int k = -1; k < 8; k++) begin
            for (int w = 0; w < 2; w++) begin
                int t;
                t = 10 + (k + 1) * 2 + w;
                clear_log();
                gnt_en = 1;
                stop_at = k;
                stop_with = (w == 0);
                wait_n = (k + 1 + w) % 3;
                for (int i = 0; i < 4; i++) begin
                    sb_put(mka(t, i, 8), mkd(t, i), mkbe(t, i), 2'd1, 1, 0, ok, waited, acc);
                    chk("R3", "burst beat ack", ok, 1);
                    if (i == 2) begin
                        chk("R5", "no request while open", pci_req, 0);
                        chk("R5", "no address phase while open", naddr, 0);
                    end
                end
                wait_words(8);
                chk("R10", "no loss or duplicate", nwords, 8);
                for (int i = 0; i < 4; i++)
                    chk_entry("R5", 2 * i, mka(t, i, 8), mkd(t, i), mkbe(t, i), 4'b0111);
                chk("R10", "address phases", naddr, (k < 0 || (k == 7 && w == 0)) ? 1 : 2);
                chk("R11", "buf_empty after burst", buf_empty, 1);
            end
        end

        // R3 R8: burst is held off while a single is buffered
        clear_log();
        gnt_en = 0;
        sb_put(mka(40, 0, 8), mkd(40, 0), mkbe(40, 0), 2'd0, 0, 0, ok, waited, acc);
        chk("R1", "single before burst", ok, 1);
        sb_put(mka(41, 0, 8), mkd(41, 0), mkbe(41, 0), 2'd0, 1, 4, ok, waited, acc);
        chk("R3", "burst stalled into non-empty buffer", ok, 0);
        gnt_en = 1;
        for (int i = 0; i < 4; i++) begin
            sb_put(mka(41, i, 8), mkd(41, i), mkbe(41, i), 2'd0, 1, 500, ok, waited, acc);
            chk("R3", "burst beat after drain", ok, 1);
        end
        wait_words(10);
        chk_entry("R8", 0, mka(40, 0, 8), mkd(40, 0), mkbe(40, 0), 4'b0111);
        for (int i = 0; i < 4; i++)
            chk_entry("R5", 2 + 2 * i, mka(41, i, 8), mkd(41, i), mkbe(41, i), 4'b0111);
        chk("R5", "address phases", naddr, 2);

        // R6 R7 R8: connected writes behind a posted one
        for (int sp = 1; sp <= 3; sp++) begin
            logic [3:0] ecmd;
            ecmd = (sp == 1) ? 4'b0011 : (sp == 2) ? 4'b1011 : 4'b0001;
            clear_log();
            gnt_en = 0;
            sb_put(mka(50 + sp, 0, 8), mkd(50 + sp, 0), mkbe(50 + sp, 0), 2'd0, 0, 0, ok, waited, acc);
            chk("R1", "posted before connected", ok, 1);
            fork
                begin repeat (6) @(negedge clk); gnt_en = 1; end
                sb_put(mka(60 + sp, 0, 8), mkd(60 + sp, 0), mkbe(60 + sp, 0), 2'(sp), 0, 400, ok, waited, acc);
            join
            chk("R7", "connected acked", ok, 1);
            chk("R7", "held while bus withheld", waited >= 6, 1);
            chk("R7", "ack cycle after final word", acc, last_cyc + 1);
            chk("R7", "buffer empty at ack", buf_empty, 1);
            chk("R8", "word count", nwords, 4);
            chk_entry("R8", 0, mka(50 + sp, 0, 8), mkd(50 + sp, 0), mkbe(50 + sp, 0), 4'b0111);
            chk_entry("R6", 2, mka(60 + sp, 0, 8), mkd(60 + sp, 0), mkbe(60 + sp, 0), ecmd);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule